// File: doc/BRIEF.md
# Backplane ROM Window Decoder with Byte-Level Release

This block makes the read-side decisions for a 16 KB ROM window on an 8-bit microcomputer backplane. The window holds sixteen 1 KB ROM banks. A 2-bit base setting places the window in one of the four 16 KB quadrants of the 64 KB address space. When a memory read falls inside the window, the block:

- picks the bank from the address,
- hands the low address bits to the ROM arrays as the byte offset,
- decides whether the board drives the data bus.

The data bus is driven only during the data-in strobe. It is not driven when the fetched byte is all ones. An empty socket reads as all ones, so it releases its 1 KB range, and a RAM card that honours a shared disable line can answer instead. Any single byte programmed to FF hex is released in the same way. This lets ROM and RAM share one window byte by byte.

The ROM contents arrive on a flat byte vector, one byte per bank at the current offset. Bank selects and the data decision are registered once. Each bus cycle's result therefore appears on the clock edge after its inputs are sampled. While a vector-jump sequence runs elsewhere on the board, every bank select is held inactive. A debug input turns off the all-ones release so that FF bytes are driven like any other data.

Top module: `rom_window_decode`

## Requirements
- R1: The window responds only when address bits [15:14] equal `base_sw`. The possible bases are 0000, 4000, 8000 and C000 hex.
- R2: When the window responds, `bank_cs` is one-hot. Its bit at index `bus_addr[13:10]` is set.
- R3: While `mem_read` is low, `bank_cs` is all zero and `bus_doe` is low.
- R4: When `data_in_strobe` is low, `bus_doe` is low, even if a bank is selected.
- R5: If the selected byte is FF hex and `ff_ignore` is low, `bus_doe` is low. An empty bank reads as FF hex.
- R6: While `vector_active` is high, `bank_cs` is all zero and `bus_doe` is low.
- R7: Whenever `bus_doe` is low, `bus_dout` is zero.
- R8: `rom_offset` equals `bus_addr[9:0]` in the same cycle, with no register in the path.
- R9: With `ff_ignore` high, an FF hex byte is driven on `bus_dout` with `bus_doe` high.
- R10: During reset, `bank_cs`, `bus_doe` and `bus_dout` are zero.
- R11: `bank_cs`, `bus_doe` and `bus_dout` reflect the inputs sampled at the previous rising clock edge. An idle cycle after a driven read returns them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 16 | Bus address |
| base_sw | input | 2 | Quadrant setting compared with address bits [15:14] |
| mem_read | input | 1 | Memory-read status of the current bus cycle |
| data_in_strobe | input | 1 | Data-in strobe from the processor |
| vector_active | input | 1 | High while a vector-jump sequence runs |
| ff_ignore | input | 1 | Debug: drive FF bytes instead of releasing them |
| bank_rdata | input | 128 | Byte from each bank at `rom_offset`; bank n in bits [8n+7:8n] |
| rom_offset | output | 10 | Byte offset within each bank |
| bank_cs | output | 16 | Registered one-hot bank select |
| bus_dout | output | 8 | Registered data toward the bus; zero when not driving |
| bus_doe | output | 1 | Registered output enable of the data buffers |

## Verification
The properties assume that `bank_rdata` settles within the same cycle from `rom_offset`, as a combinational ROM model would. They also assume that all control inputs are stable at each rising edge. The stimulus meets both conditions. It changes every input only on the falling edge, and it builds `bank_rdata` from a fixed per-bank content function addressed by `rom_offset`. That content function marks two whole banks as empty and places one isolated FF byte in a populated bank. This lets both forms of release be reached without breaking the input assumptions.

// File: rtl/rom_window_decode.sv
module rom_window_decode #(
  parameter int ADDR_W  = 16,
  parameter int BANK_AW = 10,
  parameter int NBANK   = 16,
  parameter int DATA_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [15:0]             bus_addr,
  input  logic [1:0]              base_sw,
  input  logic                    mem_read,
  input  logic                    data_in_strobe,
  input  logic                    vector_active,
  input  logic                    ff_ignore,
  input  logic [127:0]            bank_rdata,
  output logic [9:0]              rom_offset,
  output logic [15:0]             bank_cs,
  output logic [7:0]              bus_dout,
  output logic                    bus_doe
);
  localparam int BSEL_W = $clog2(NBANK);
  localparam int QUAD_W = ADDR_W - BSEL_W - BANK_AW;

  logic [BSEL_W-1:0] bank_idx;
  logic [DATA_W-1:0] rd_byte;
  logic              window_hit, bank_go, release_ff, drive;
  logic [NBANK-1:0]  cs_next;

  assign rom_offset = bus_addr[BANK_AW-1:0];
  assign bank_idx   = bus_addr[BANK_AW +: BSEL_W];
  assign rd_byte    = bank_rdata[bank_idx*DATA_W +: DATA_W];
  assign window_hit = (bus_addr[ADDR_W-1 -: QUAD_W] == base_sw) && mem_read;
  assign bank_go    = window_hit && !vector_active;
  assign release_ff = (&rd_byte) && !ff_ignore;
  assign drive      = bank_go && data_in_strobe && !release_ff;
  assign cs_next    = bank_go ? (NBANK'(1) << bank_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_cs  <= '0;
      bus_doe  <= 1'b0;
      bus_dout <= '0;
    end else begin
      bank_cs  <= cs_next;
      bus_doe  <= drive;
      bus_dout <= drive ? rd_byte : '0;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cs));                                                      // R2
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_doe |-> bus_dout == '0);                                            // R7
  AST_VECTOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    vector_active |=> (bank_cs == '0 && !bus_doe));                          // R6
  AST_NO_READ_NO_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_read |=> (bank_cs == '0 && !bus_doe));                              // R3
  AST_STROBE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !data_in_strobe |=> !bus_doe);                                           // R4
  AST_FF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_doe && !$past(ff_ignore)) |-> bus_dout != 8'hFF);                   // R5
  AST_DRIVE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bank_cs != '0);                                              // R1
endmodule

// File: tb/sim_rom_window_decode.sv
module sim_rom_window_decode;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [1:0] base_sw = '0;
  logic mem_read = 0, data_in_strobe = 0, vector_active = 0, ff_ignore = 0;
  logic [127:0] bank_rdata;
  logic [9:0] rom_offset;
  logic [15:0] bank_cs;
  logic [7:0] bus_dout;
  logic bus_doe;

  typedef struct packed { logic [15:0] cs; logic oe; logic [7:0] d; } exp_t;
  exp_t exp_q[$];
  string tag_q[$];
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rom_window_decode u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .base_sw(base_sw),
    .mem_read(mem_read), .data_in_strobe(data_in_strobe), .vector_active(vector_active),
    .ff_ignore(ff_ignore), .bank_rdata(bank_rdata), .rom_offset(rom_offset),
    .bank_cs(bank_cs), .bus_dout(bus_dout), .bus_doe(bus_doe));

  function automatic logic [7:0] rom_byte(input int b, input logic [9:0] o);
    if (b == 5 || b == 12) return 8'hFF;
    if (b == 3 && o == 10'h010) return 8'hFF;
    return 8'((b * 29 + int'(o) * 3)) & 8'hFE;
  endfunction

  always_comb
    for (int b = 0; b < 16; b++) bank_rdata[b*8 +: 8] = rom_byte(b, rom_offset);

  task automatic drive(input logic [15:0] a, input logic [1:0] sw, input logic mr,
                       input logic stb, input logic vec, input logic ign, input string tag);
    exp_t e;
    logic go;
    logic [7:0] byt;
    @(negedge clk);
    bus_addr = a; base_sw = sw; mem_read = mr; data_in_strobe = stb;
    vector_active = vec; ff_ignore = ign;
    go  = (a[15:14] == sw) && mr && !vec;
    byt = rom_byte(int'(a[13:10]), a[9:0]);
    e.cs = go ? (16'd1 << a[13:10]) : 16'd0;
    e.oe = go && stb && !(byt == 8'hFF && !ign);
    e.d  = e.oe ? byt : 8'd0;
    #1;
    total++;
    if (rom_offset !== a[9:0]) begin
      bad++;
      $display("FAIL R8 offset actual=%h expected=%h", rom_offset, a[9:0]);
    end
    @(posedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (bank_cs !== e.cs || bus_doe !== e.oe || bus_dout !== e.d) begin
        bad++;
        $display("FAIL %s actual cs=%h oe=%b d=%h expected cs=%h oe=%b d=%h",
                 t, bank_cs, bus_doe, bus_dout, e.cs, e.oe, e.d);
      end
    end
  end

  initial begin
    #2000000;
    if (!finished) begin
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    bus_addr = 16'h8400; base_sw = 2'd2; mem_read = 1; data_in_strobe = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;  // R10
    if (bank_cs !== 0 || bus_doe !== 0 || bus_dout !== 0) begin
      bad++;
      $display("FAIL R10 actual cs=%h oe=%b d=%h expected all zero", bank_cs, bus_doe, bus_dout);
    end
    rst_n = 1;
    for (int q = 0; q < 4; q++)
      drive({q[1:0], 4'(q * 3 + 1), 10'h021}, q[1:0], 1, 1, 0, 0, "R1 quadrant match");
    drive(16'h8800, 2'd1, 1, 1, 0, 0, "R1 quadrant mismatch");
    drive(16'h0400, 2'd3, 1, 1, 0, 0, "R1 quadrant mismatch low");
    for (int b = 0; b < 16; b++)
      drive({2'b11, 4'(b), 10'(b * 61)}, 2'd3, 1, 1, 0, 0, "R2 bank decode");
    drive(16'h4C40, 2'd1, 0, 1, 0, 0, "R3 no memory read");
    drive(16'h4C40, 2'd1, 1, 0, 0, 0, "R4 strobe low");
    drive(16'h1400, 2'd0, 1, 1, 0, 0, "R5 empty bank");
    drive(16'hF3FF, 2'd3, 1, 1, 0, 0, "R5 empty bank top");
    drive(16'h0C10, 2'd0, 1, 1, 0, 0, "R5 single FF byte");
    drive(16'h0C11, 2'd0, 1, 1, 0, 0, "R5 neighbour byte drives");
    drive(16'h0C10, 2'd0, 1, 1, 0, 1, "R9 ff_ignore drives FF");
    drive(16'h1400, 2'd0, 1, 1, 0, 1, "R9 empty bank forced");
    drive(16'h8800, 2'd2, 1, 1, 1, 0, "R6 vector active");
    drive(16'h8800, 2'd2, 1, 1, 0, 0, "R11 drive before idle");
    drive(16'h8800, 2'd2, 0, 0, 0, 0, "R11 idle returns zero R7");
    drive(16'hBFFE, 2'd2, 1, 1, 0, 0, "R1 window top edge");
    repeat (3) @(posedge clk);
    @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule